// File: doc/BRIEF.md
# I2C Register-Mapped Target Emulator

This block is an I2C target that stands in for a register-based peripheral. It answers one 7-bit device address and exposes an 8-bit register space (256 pointer values) through the usual sequence: the controller writes a pointer byte and may follow it with data bytes, or it issues a repeated START and reads from the pointer. The register map is set by parameters. Each mapped slot has an address, a reset value, a read-only or read-write rule, and an optional dynamic flag. Addresses with no slot read back a fill value. A dynamic slot takes its read value from a per-slot input bus instead of its stored contents, so a stream source such as a FIFO can replay changing data. Every byte read from such a slot gives a one-cycle pop strobe that carries the slot index.

SCL and SDA are synchronized to the system clock and turned into START, STOP, rise and fall events. A protocol state machine steps through the states ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_BYTE, ST_WR_ACK, ST_RD_BYTE and ST_RD_ACK:

- A START moves it from any state to ST_ADDR. A STOP moves it from any state to ST_IDLE.
- ST_ADDR goes to ST_ADDR_ACK on a match and to ST_IDLE on a mismatch.
- ST_ADDR_ACK goes to ST_RD_BYTE or ST_WR_BYTE, depending on the direction bit.
- ST_WR_BYTE and ST_WR_ACK alternate on each byte.
- ST_RD_BYTE goes to ST_RD_ACK. ST_RD_ACK goes back to ST_RD_BYTE when the controller acknowledges, and to ST_IDLE when it does not.

When enabled, the general-call address is acknowledged and reported as a one-cycle event. SDA is driven as an open-drain enable. The block does not stretch the clock.

Top module: `i2c_regmap_target`

## Requirements
- R1: An address byte whose upper seven bits differ from DEV_ADDR, and which is not an enabled general call, is not acknowledged. SDA stays released until the next START.
- R2: In a write transaction, the first byte after the address loads the register pointer. Each later byte is written to the register at the pointer, if that register is read-write.
- R3: A read transaction returns bytes starting at the current pointer. This holds both for a bare read and for a pointer write followed by a repeated START and a read.
- R4: With AUTO_INC=1, each transferred data byte (read, or written after the pointer byte) advances the pointer by one, wrapping from 0xFF to 0x00. With AUTO_INC=0 the pointer does not move.
- R5: Writes to a read-only register leave its value unchanged. Each register holds its parameter default after reset.
- R6: A pointer value with no mapped slot reads back FILL (0xFF by default), and writes to it are dropped.
- R7: With GC_EN=1, address byte 0x00 is acknowledged, gc_evt_o pulses for one cycle, and the data bytes that follow are acknowledged but change neither the pointer nor any register. With GC_EN=0, address byte 0x00 is not acknowledged and there is no event.
- R8: A dynamic slot reads from its byte lane of dyn_data_i (slot k uses bits 8k+7 to 8k). Each byte read from it gives one single-cycle dyn_pop_o, with dyn_pop_idx_o equal to k.
- R9: SDA is released during the controller's ACK slot of a read. After a NACK it stays released until the next START.
- R10: A START or STOP in the middle of a byte abandons that byte, releases SDA and discards the partial write. A repeated START returns the target to address matching.
- R11: After reset, sda_oe_o, gc_evt_o and dyn_pop_o are low, and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | SDA line level (asynchronous) |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| dyn_data_i | input | NREG*8 | Per-slot dynamic read data, slot k in byte lane k |
| dyn_pop_o | output | 1 | One-cycle strobe when a dynamic slot byte is read |
| dyn_pop_idx_o | output | IDXW | Slot index that goes with dyn_pop_o |
| gc_evt_o | output | 1 | One-cycle pulse when a general call is acknowledged |

## Verification
Each bus edge reaches the state machine after two synchronizer flops and one edge-detect flop. SDA decisions, the pop strobe and the general-call pulse therefore appear three system clocks after the SCL fall that causes them. Register writes land one clock later again.

The bench drives SCL and SDA in quarter-bit phases of eight clocks. It reads SDA in the middle of each high phase, by which time every response is settled. It counts the pop and general-call strobes on every clock edge and watches SDA on every cycle of the windows where the target must stay silent. A behavioural register and pointer model in the bench supplies the expected value for each byte read.

// File: rtl/i2c_regmap_pkg.sv
package i2c_regmap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } tgt_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic scl;
        logic sda;
    } bus_evt_t;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync
    import i2c_regmap_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    always_comb begin
        evt_o.start = scl_s & scl_q & sda_q & ~sda_s;
        evt_o.stop  = scl_s & scl_q & ~sda_q & sda_s;
        evt_o.rise  = scl_s & ~scl_q;
        evt_o.fall  = ~scl_s & scl_q;
        evt_o.scl   = scl_s;
        evt_o.sda   = sda_s;
    end

endmodule

// File: rtl/i2c_regfile.sv
module i2c_regfile #(
    parameter int                NREG     = 4,
    parameter int                IDXW     = 2,
    parameter logic [NREG*8-1:0] REG_ADDR = {8'h30, 8'h20, 8'h10, 8'h00},
    parameter logic [NREG*8-1:0] REG_DEF  = {8'h5A, 8'hA0, 8'h00, 8'h12},
    parameter logic [NREG-1:0]   REG_RW   = 4'b1010,
    parameter logic [NREG-1:0]   REG_DYN  = 4'b0100,
    parameter logic [7:0]        FILL     = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rd_ptr,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [NREG*8-1:0] dyn_data,
    output logic [7:0]        rd_data,
    output logic              rd_dyn,
    output logic [IDXW-1:0]   rd_idx
);

    logic [NREG*8-1:0] slot_flat;
    logic [NREG-1:0]   hit_rd;
    logic [NREG-1:0]   hit_wr;

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        logic [7:0] val_q;

        assign hit_rd[g] = (rd_ptr == REG_ADDR[g*8 +: 8]);
        assign hit_wr[g] = (wr_addr == REG_ADDR[g*8 +: 8]);
        assign slot_flat[g*8 +: 8] = val_q;

        if (REG_RW[g]) begin : g_rw
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= REG_DEF[g*8 +: 8];
                end else if (wr_en && hit_wr[g]) begin
                    val_q <= wr_data;
                end
            end

            // R2: a write hitting a read-write slot stores the byte
            p_rw_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && hit_wr[g]) |=> (val_q == $past(wr_data)));
        end else begin : g_ro
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= REG_DEF[g*8 +: 8];
                end
            end

            // R5: a write hitting a read-only slot leaves it untouched
            p_ro_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && hit_wr[g]) |=> $stable(val_q));
        end
    end

    always_comb begin
        rd_data = FILL;
        rd_dyn  = 1'b0;
        rd_idx  = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit_rd[i]) begin
                rd_data = REG_DYN[i] ? dyn_data[i*8 +: 8] : slot_flat[i*8 +: 8];
                rd_dyn  = REG_DYN[i];
                rd_idx  = IDXW'(i);
            end
        end
    end

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_regmap_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h42,
    parameter bit         AUTO_INC = 1'b1,
    parameter bit         GC_EN    = 1'b1,
    parameter int         NREG     = 4,
    parameter int         IDXW     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  bus_evt_t        evt,
    input  logic [7:0]      rd_data,
    input  logic            rd_dyn,
    input  logic [IDXW-1:0] rd_idx,
    output logic [7:0]      ptr_o,
    output logic            wr_en_o,
    output logic [7:0]      wr_addr_o,
    output logic [7:0]      wr_data_o,
    output logic            sda_oe_o,
    output logic            gc_evt_o,
    output logic            pop_o,
    output logic [IDXW-1:0] pop_idx_o
);

    localparam logic [7:0] STEP = AUTO_INC ? 8'd1 : 8'd0;
    localparam logic [3:0] BITS = 4'd8;

    tgt_state_e st_q, st_d;
    logic [3:0] cnt_q;
    logic [7:0] sh_q;
    logic [7:0] tx_q;
    logic       first_q;
    logic       rw_q;
    logic       gc_q;
    logic       mack_q;
    logic       addr_hit;
    logic       gc_hit;
    logic       abort;
    logic       load_now;

    assign gc_hit   = GC_EN && (sh_q == 8'h00);
    assign addr_hit = (sh_q[7:1] == DEV_ADDR) || gc_hit;
    assign abort    = evt.start | evt.stop;
    assign load_now = evt.fall &&
                      (((st_q == ST_ADDR_ACK) && rw_q) || ((st_q == ST_RD_ACK) && mack_q));

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (evt.stop) begin
            st_d = ST_IDLE;
        end else if (evt.start) begin
            st_d = ST_ADDR;
        end else begin
            unique case (st_q)
                ST_IDLE:     st_d = ST_IDLE;
                ST_ADDR:     if (evt.fall && cnt_q == BITS) st_d = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (evt.fall) st_d = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (evt.fall && cnt_q == BITS) st_d = ST_WR_ACK;
                ST_WR_ACK:   if (evt.fall) st_d = ST_WR_BYTE;
                ST_RD_BYTE:  if (evt.fall && cnt_q == BITS) st_d = ST_RD_ACK;
                ST_RD_ACK:   if (evt.fall) st_d = mack_q ? ST_RD_BYTE : ST_IDLE;
                default:     st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            sh_q      <= '0;
            tx_q      <= '0;
            ptr_o     <= '0;
            first_q   <= 1'b1;
            rw_q      <= 1'b0;
            gc_q      <= 1'b0;
            mack_q    <= 1'b0;
            sda_oe_o  <= 1'b0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
            gc_evt_o  <= 1'b0;
            pop_o     <= 1'b0;
            pop_idx_o <= '0;
        end else begin
            wr_en_o  <= 1'b0;
            gc_evt_o <= 1'b0;
            pop_o    <= 1'b0;
            if (abort) begin
                cnt_q    <= '0;
                sda_oe_o <= 1'b0;
                first_q  <= 1'b1;
                gc_q     <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_IDLE: begin
                    end
                    ST_ADDR: begin
                        if (evt.rise) begin
                            sh_q  <= {sh_q[6:0], evt.sda};
                            cnt_q <= cnt_q + 4'd1;
                        end
                        if (evt.fall && cnt_q == BITS && addr_hit) begin
                            sda_oe_o <= 1'b1;
                            rw_q     <= sh_q[0];
                            gc_q     <= gc_hit;
                            gc_evt_o <= gc_hit;
                            cnt_q    <= '0;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.fall) begin
                            sda_oe_o <= 1'b0;
                            cnt_q    <= '0;
                        end
                    end
                    ST_WR_BYTE: begin
                        if (evt.rise) begin
                            sh_q  <= {sh_q[6:0], evt.sda};
                            cnt_q <= cnt_q + 4'd1;
                        end
                        if (evt.fall && cnt_q == BITS) begin
                            sda_oe_o <= 1'b1;
                            cnt_q    <= '0;
                            if (!gc_q) begin
                                if (first_q) begin
                                    ptr_o   <= sh_q;
                                    first_q <= 1'b0;
                                end else begin
                                    wr_en_o   <= 1'b1;
                                    wr_addr_o <= ptr_o;
                                    wr_data_o <= sh_q;
                                    ptr_o     <= ptr_o + STEP;
                                end
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (evt.fall) begin
                            sda_oe_o <= 1'b0;
                            cnt_q    <= '0;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (evt.rise) begin
                            cnt_q <= cnt_q + 4'd1;
                        end
                        if (evt.fall) begin
                            if (cnt_q == BITS) begin
                                sda_oe_o <= 1'b0;
                            end else begin
                                tx_q     <= {tx_q[6:0], 1'b0};
                                sda_oe_o <= ~tx_q[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (evt.rise) begin
                            mack_q <= ~evt.sda;
                        end
                        if (evt.fall) begin
                            sda_oe_o <= 1'b0;
                        end
                    end
                    default: begin
                    end
                endcase
                if (load_now) begin
                    tx_q      <= rd_data;
                    sda_oe_o  <= ~rd_data[7];
                    ptr_o     <= ptr_o + STEP;
                    pop_o     <= rd_dyn;
                    pop_idx_o <= rd_idx;
                    cnt_q     <= '0;
                end
            end
        end
    end

    // R7: the general-call event lasts one cycle
    p_gc_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gc_evt_o |=> !gc_evt_o);

    // R7: the event comes with the address acknowledge
    p_gc_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gc_evt_o |-> sda_oe_o);

    // R8: pop strobe is a single cycle
    p_pop_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o |=> !pop_o);

    // R8: pop index names an existing slot
    p_pop_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o |-> (int'(pop_idx_o) < NREG));

    // R10: START or STOP releases SDA
    p_abort_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !sda_oe_o);

    // R9: SDA drive only changes after SCL low or a bus condition
    p_sda_when_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> ($past(evt.start) || $past(evt.stop) || !$past(evt.scl)));

    // R1: once idle, the target stays silent until a START
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !evt.start) |=> !sda_oe_o);

endmodule

// File: rtl/i2c_regmap_target.sv
module i2c_regmap_target
    import i2c_regmap_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR    = 7'h42,
    parameter bit                AUTO_INC    = 1'b1,
    parameter bit                GC_EN       = 1'b1,
    parameter int                SYNC_STAGES = 2,
    parameter int                NREG        = 4,
    parameter logic [NREG*8-1:0] REG_ADDR    = {8'h30, 8'h20, 8'h10, 8'h00},
    parameter logic [NREG*8-1:0] REG_DEF     = {8'h5A, 8'hA0, 8'h00, 8'h12},
    parameter logic [NREG-1:0]   REG_RW      = 4'b1010,
    parameter logic [NREG-1:0]   REG_DYN     = 4'b0100,
    parameter logic [7:0]        FILL        = 8'hFF,
    localparam int               IDXW        = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [NREG*8-1:0] dyn_data_i,
    output logic              dyn_pop_o,
    output logic [IDXW-1:0]   dyn_pop_idx_o,
    output logic              gc_evt_o
);

    bus_evt_t        evt;
    logic [7:0]      ptr;
    logic            wr_en;
    logic [7:0]      wr_addr;
    logic [7:0]      wr_data;
    logic [7:0]      rd_data;
    logic            rd_dyn;
    logic [IDXW-1:0] rd_idx;

    i2c_bus_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .evt_o(evt)
    );

    i2c_regfile #(
        .NREG    (NREG),
        .IDXW    (IDXW),
        .REG_ADDR(REG_ADDR),
        .REG_DEF (REG_DEF),
        .REG_RW  (REG_RW),
        .REG_DYN (REG_DYN),
        .FILL    (FILL)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_ptr  (ptr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dyn_data(dyn_data_i),
        .rd_data (rd_data),
        .rd_dyn  (rd_dyn),
        .rd_idx  (rd_idx)
    );

    i2c_target_fsm #(
        .DEV_ADDR(DEV_ADDR),
        .AUTO_INC(AUTO_INC),
        .GC_EN   (GC_EN),
        .NREG    (NREG),
        .IDXW    (IDXW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .rd_data  (rd_data),
        .rd_dyn   (rd_dyn),
        .rd_idx   (rd_idx),
        .ptr_o    (ptr),
        .wr_en_o  (wr_en),
        .wr_addr_o(wr_addr),
        .wr_data_o(wr_data),
        .sda_oe_o (sda_oe_o),
        .gc_evt_o (gc_evt_o),
        .pop_o    (dyn_pop_o),
        .pop_idx_o(dyn_pop_idx_o)
    );

endmodule

// File: tb/i2c_regmap_target_tb_top.sv
module i2c_regmap_target_tb_top;

    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        oe_a, oe_b;
    logic        pop_a, pop_b, gc_a, gc_b;
    logic [1:0]  idx_a, idx_b;
    logic [7:0]  dyn_val = 8'h30;
    logic [31:0] dyn_bus;
    wire         sda_line;

    assign sda_line = m_sda & ~oe_a & ~oe_b;
    assign dyn_bus  = {8'h00, dyn_val, 16'h0000};

    always #4 clk = ~clk;

    i2c_regmap_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe_o(oe_a), .dyn_data_i(dyn_bus), .dyn_pop_o(pop_a),
        .dyn_pop_idx_o(idx_a), .gc_evt_o(gc_a)
    );

    i2c_regmap_target #(.DEV_ADDR(7'h43), .AUTO_INC(1'b0), .GC_EN(1'b0)) dut_b (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe_o(oe_b), .dyn_data_i(32'h0), .dyn_pop_o(pop_b),
        .dyn_pop_idx_o(idx_b), .gc_evt_o(gc_b)
    );

    int n_chk = 0;
    int n_err = 0;
    int pop_cnt = 0;
    int pop_bad = 0;
    int gc_cnt = 0;
    int gc_b_cnt = 0;
    bit quiet = 1'b0;
    bit quiet_bad = 1'b0;
    bit done = 1'b0;
    logic [7:0] rbuf [4];

    // reference model of dut_i
    logic [7:0] mem [256];
    bit         mrw [256];
    bit         mdyn [256];
    int         mptr = 0;
    int         mdval = 8'h30;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read();
        logic [7:0] v;
        if (mdyn[mptr]) begin
            v = mdval[7:0];
            mdval++;
        end else begin
            v = mem[mptr];
        end
        mptr = (mptr + 1) % 256;
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            if (pop_a) begin
                pop_cnt++;
                dyn_val <= dyn_val + 8'd1;
                if (idx_a != 2'd2) pop_bad++;
            end
            if (pop_b) pop_bad++;
            if (gc_a) gc_cnt++;
            if (gc_b) gc_b_cnt++;
        end
    end

    always @(negedge clk) begin
        if (quiet && (oe_a || oe_b)) quiet_bad = 1'b1;
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bstart();
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic bstop();
        m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    task automatic bit_out(input logic b);
        m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    endtask

    task automatic bit_in(output logic v);
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); v = sda_line; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) bit_out(b[i]);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        logic a;
        send_bits(b, 8);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic recv_byte(input bit last, output logic [7:0] b);
        logic v;
        bit slot_oe;
        for (int i = 7; i >= 0; i--) begin
            bit_in(v);
            b[i] = v;
        end
        m_sda = last; wq(); m_scl = 1'b1; wq(); slot_oe = oe_a | oe_b; wq(); m_scl = 1'b0; wq();
        m_sda = 1'b1;
        chk(!slot_oe, "R9 SDA released in controller ACK slot", slot_oe, 0);
    endtask

    task automatic wr_txn(input logic [6:0] dev, input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input logic [7:0] d3, input int n, input string tag);
        logic [7:0] d [4];
        bit ack;
        bit all_ack = 1'b1;
        d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
        bstart();
        send_byte({dev, 1'b0}, ack);
        all_ack &= ack;
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], ack);
            all_ack &= ack;
        end
        bstop();
        chk(all_ack, tag, all_ack, 1);
        if (dev == 7'h42) begin
            mptr = d[0];
            for (int k = 1; k < n; k++) begin
                if (mrw[mptr]) mem[mptr] = d[k];
                mptr = (mptr + 1) % 256;
            end
        end
    endtask

    task automatic rd_txn(input logic [6:0] dev, input bit setp, input logic [7:0] p, input int n);
        bit ack;
        bit all_ack = 1'b1;
        bstart();
        if (setp) begin
            send_byte({dev, 1'b0}, ack); all_ack &= ack;
            send_byte(p, ack); all_ack &= ack;
            bstart();
            if (dev == 7'h42) mptr = p;
        end
        send_byte({dev, 1'b1}, ack); all_ack &= ack;
        for (int k = 0; k < n; k++) recv_byte(k == n - 1, rbuf[k]);
        quiet_bad = 1'b0;
        quiet = 1'b1;
        bstop();
        quiet = 1'b0;
        chk(all_ack, "R3 read transaction acknowledged", all_ack, 1);
        chk(!quiet_bad, "R9 SDA released after NACK", quiet_bad, 0);
    endtask

    task automatic rd_model(input bit setp, input logic [7:0] p, input int n, input string tag);
        logic [7:0] e;
        rd_txn(7'h42, setp, p, n);
        for (int k = 0; k < n; k++) begin
            e = m_read();
            chk(rbuf[k] == e, tag, rbuf[k], e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        bit ack, ack2;
        int gc0;
        for (int a = 0; a < 256; a++) begin
            mem[a] = 8'hFF; mrw[a] = 1'b0; mdyn[a] = 1'b0;
        end
        mem[8'h00] = 8'h12;
        mem[8'h10] = 8'h00; mrw[8'h10] = 1'b1;
        mem[8'h20] = 8'hA0; mdyn[8'h20] = 1'b1;
        mem[8'h30] = 8'h5A; mrw[8'h30] = 1'b1;

        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R11 reset state
        chk(!oe_a && !oe_b, "R11 SDA released after reset", oe_a, 0);
        chk(!gc_a && !pop_a, "R11 strobes low after reset", {gc_a, pop_a}, 0);

        // R11/R3: bare read from the reset pointer 0x00
        rd_model(1'b0, 8'h00, 1, "R11 R3 bare read from reset pointer");

        // R2: pointer then data, second data byte to an unmapped address
        wr_txn(7'h42, 8'h10, 8'hC3, 8'h77, 8'h00, 3, "R2 write acknowledged");
        rd_model(1'b1, 8'h10, 1, "R2 written value read back");

        // R3/R4/R6: burst across unmapped and mapped addresses
        rd_model(1'b1, 8'h0F, 3, "R4 R6 auto-increment burst with fill");

        // R5: read-only slot keeps its default
        wr_txn(7'h42, 8'h00, 8'h99, 8'h00, 8'h00, 2, "R5 write to read-only acknowledged");
        rd_model(1'b1, 8'h00, 1, "R5 read-only unchanged");
        wr_txn(7'h42, 8'h30, 8'h11, 8'h22, 8'h00, 3, "R2 burst write acknowledged");
        rd_model(1'b1, 8'h30, 2, "R2 R6 burst write landed");

        // R8: dynamic slot
        rd_model(1'b1, 8'h20, 1, "R8 dynamic first sample");
        rd_model(1'b1, 8'h20, 1, "R8 dynamic second sample");
        chk(pop_cnt == 2, "R8 one pop per dynamic byte", pop_cnt, 2);
        chk(pop_bad == 0, "R8 pop index is slot 2", pop_bad, 0);

        // R4: wrap from 0xFF to 0x00
        rd_model(1'b1, 8'hFF, 2, "R4 pointer wraps");

        // R1: foreign address stays silent
        quiet_bad = 1'b0;
        quiet = 1'b1;
        bstart();
        send_byte({7'h55, 1'b0}, ack);
        send_byte(8'h10, ack2);
        bstop();
        quiet = 1'b0;
        chk(!ack && !ack2, "R1 foreign address not acknowledged", {ack, ack2}, 0);
        chk(!quiet_bad, "R1 SDA never driven for foreign address", quiet_bad, 0);
        rd_model(1'b0, 8'h00, 1, "R1 pointer unchanged by foreign traffic");

        // R7: general call
        wr_txn(7'h42, 8'h10, 8'h00, 8'h00, 8'h00, 1, "R7 pointer set before general call");
        gc0 = gc_cnt;
        bstart();
        send_byte(8'h00, ack);
        send_byte(8'h30, ack2);
        bstop();
        chk(ack && ack2, "R7 general call and data acknowledged", {ack, ack2}, 3);
        chk(gc_cnt == gc0 + 1, "R7 single general-call event", gc_cnt, gc0 + 1);
        chk(gc_b_cnt == 0, "R7 no event when disabled", gc_b_cnt, 0);
        rd_model(1'b0, 8'h00, 1, "R7 general-call data left pointer alone");

        // R10: STOP in mid-byte discards the partial write
        bstart();
        send_byte({7'h42, 1'b0}, ack);
        send_byte(8'h30, ack2);
        send_bits(8'hEE, 5);
        bstop();
        mptr = 8'h30;
        rd_model(1'b0, 8'h00, 1, "R10 partial write after STOP discarded");

        // R10: repeated START in mid-byte returns to address matching
        bstart();
        send_byte({7'h42, 1'b0}, ack);
        send_byte(8'h10, ack2);
        send_bits(8'hAA, 3);
        bstart();
        send_byte({7'h42, 1'b1}, ack);
        recv_byte(1'b1, rbuf[0]);
        bstop();
        mptr = 8'h10;
        chk(ack && ack2, "R10 address matched after repeated START", {ack, ack2}, 3);
        begin
            logic [7:0] e;
            e = m_read();
            chk(rbuf[0] == e, "R10 read after mid-byte repeated START", rbuf[0], e);
        end

        // R4: no auto-increment on dut_b
        wr_txn(7'h43, 8'h10, 8'h01, 8'h02, 8'h03, 4, "R4 fixed-pointer write acknowledged");
        rd_txn(7'h43, 1'b1, 8'h10, 2);
        chk(rbuf[0] == 8'h03, "R4 fixed pointer holds last byte", rbuf[0], 8'h03);
        chk(rbuf[1] == 8'h03, "R4 fixed pointer repeats on read", rbuf[1], 8'h03);
        chk(pop_bad == 0, "R8 no stray pops", pop_bad, 0);

        repeat (20) @(negedge clk);
        finish_run();
    end

endmodule